// File: doc/BRIEF.md
# Serial Digit Readout with Energy Envelope Output

This block sits behind a tone-pair detector. It holds the detector's 4-bit digit code and sends it out on a single serial pin when an external controller clocks it with acknowledge pulses. The code goes out least significant bit first, one bit per pulse. When no readout is in progress, the same pin carries the call-progress energy-present indication, so the controller can follow the envelope of supervisory tones.

A readout is armed by a rising edge of the steering input. Exactly four acknowledge pulses complete it. A partial sequence must be finished before another digit can be captured. Pulses after the fourth are ignored until steering rises again.

The acknowledge pin is asynchronous to the system clock. It passes through a synchronizer, and its edges are detected in the system clock domain. Powerdown holds the pin low.

Top module: `tone_digit_shifter`

## Requirements
- R1: After reset no readout is armed. Outside a readout window, and with powerdown low, `sd` equals `energy`.
- R2: A rising edge of `steer` arms a readout. While the block is not armed, acknowledge pulses leave `sd` equal to `energy`.
- R3: The first acknowledge rising edge after arming captures `digit`, and `sd` then shows bit 0 of the captured code. Later changes of `digit` do not alter the bits being read out. The code values are as follows:
  - keys 1 to 9 are their binary value;
  - key 0 is 1010;
  - `*` is 1011 and `#` is 1100;
  - A, B and C are 1101, 1110 and 1111;
  - D is 0000.
- R4: The second, third and fourth acknowledge rising edges present bits 1, 2 and 3 in turn. Each bit holds until the next rising edge.
- R5: `sd` carries captured data from the first rising edge until the falling edge of the fourth pulse. After that falling edge it shows `energy` again.
- R6: A rising edge of `steer` during an incomplete readout is discarded. The remaining pulses continue the old code, and no new code can be captured until `steer` rises again after completion.
- R7: After a complete readout, further acknowledge pulses are ignored, with `sd` equal to `energy`, until the next rising edge of `steer`.
- R8: While `pwdn` is high, `sd` is low. The readout state is kept, and the readout resumes when `pwdn` returns low.
- R9: `ack` passes through a two-stage synchronizer. `sd` responds on the third rising clock edge after an `ack` transition, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| steer | input | 1 | Steering level from the detector; a rising edge arms a readout |
| digit | input | 4 | Decoded digit code |
| ack | input | 1 | Acknowledge pulses from the controller, asynchronous, idle low |
| energy | input | 1 | Energy-present indication from the envelope detector |
| pwdn | input | 1 | Powerdown; forces `sd` low |
| sd | output | 1 | Serial data during a readout, energy envelope otherwise |

## Verification
The readout is tried with several codes, and each code separates a different fault:
- Key 0 (1010) and `#` (1100) have alternating and grouped bits, so they expose a wrong shift direction or a bit that is held too long.
- D (0000) read while `energy` is high separates data from the envelope.
- `energy` is toggled inside the window, so a mux that ends the window on the wrong edge shows up.

Pulses that arrive before arming, after a fourth pulse, and after a steering edge dropped mid-sequence each use a code whose bit 0 differs from `energy`. Any wrongful capture is therefore visible on the pin. A check two edges after each `ack` transition fixes the synchronizer latency.

// File: rtl/tds_pkg.sv
package tds_pkg;
    localparam int unsigned TDS_DEF_DIGIT_W = 4;
    localparam int unsigned TDS_DEF_SYNC    = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;
endpackage

// File: rtl/tds_sync.sv
module tds_sync #(
    parameter int unsigned STAGES = tds_pkg::TDS_DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            nxt_d.chain[i] = cur_q.chain[i-1];
        end
        nxt_d.prev = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise = cur_q.chain[STAGES-1] & ~cur_q.prev;
    assign fall = ~cur_q.chain[STAGES-1] & cur_q.prev;
endmodule

// File: rtl/tds_ctrl.sv
module tds_ctrl #(
    parameter int unsigned DATA_W = tds_pkg::TDS_DEF_DIGIT_W,
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer,
    input  logic [DATA_W-1:0] digit,
    input  logic              ack_rise,
    input  logic              ack_fall,
    output logic              window,
    output logic              data_bit,
    output logic              armed,
    output logic [CNT_W-1:0]  count
);
    import tds_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic              steer_q;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  steer_rise;

    assign steer_rise = steer & ~cur_q.steer_q;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.steer_q = steer;
        unique case (cur_q.phase)
            PH_IDLE, PH_ARMED: begin
                if (cur_q.phase == PH_ARMED && ack_rise) begin
                    nxt_d.phase = PH_SHIFT;
                    nxt_d.shreg = digit;
                    nxt_d.cnt   = '0;
                end else if (steer_rise) begin
                    nxt_d.phase = PH_ARMED;
                end
            end
            PH_SHIFT: begin
                // steering edges inside an unfinished readout are dropped
                if (ack_rise && cur_q.cnt != LAST) begin
                    nxt_d.cnt   = cur_q.cnt + 1'b1;
                    nxt_d.shreg = cur_q.shreg >> 1;
                end else if (ack_fall && cur_q.cnt == LAST) begin
                    nxt_d.phase = PH_IDLE;
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase   <= PH_IDLE;
            cur_q.steer_q <= 1'b0;
            cur_q.cnt     <= '0;
            cur_q.shreg   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign window   = (cur_q.phase == PH_SHIFT);
    assign armed    = (cur_q.phase == PH_ARMED);
    assign data_bit = cur_q.shreg[0];
    assign count    = cur_q.cnt;
endmodule

// File: rtl/tds_outmux.sv
module tds_outmux (
    input  logic pwdn,
    input  logic window,
    input  logic data_bit,
    input  logic energy,
    output logic sd
);
    always_comb begin
        if (pwdn)        sd = 1'b0;
        else if (window) sd = data_bit;
        else             sd = energy;
    end
endmodule

// File: rtl/tone_digit_shifter.sv
module tone_digit_shifter #(
    parameter int unsigned DATA_W      = tds_pkg::TDS_DEF_DIGIT_W,
    parameter int unsigned SYNC_STAGES = tds_pkg::TDS_DEF_SYNC,
    localparam int unsigned CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer,
    input  logic [DATA_W-1:0] digit,
    input  logic              ack,
    input  logic              energy,
    input  logic              pwdn,
    output logic              sd
);
    logic             ack_rise;
    logic             ack_fall;
    logic             window;
    logic             data_bit;
    logic             armed;
    logic [CNT_W-1:0] count;

    tds_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack),
        .rise     (ack_rise),
        .fall     (ack_fall)
    );

    tds_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .steer    (steer),
        .digit    (digit),
        .ack_rise (ack_rise),
        .ack_fall (ack_fall),
        .window   (window),
        .data_bit (data_bit),
        .armed    (armed),
        .count    (count)
    );

    tds_outmux mux_i (
        .pwdn     (pwdn),
        .window   (window),
        .data_bit (data_bit),
        .energy   (energy),
        .sd       (sd)
    );
endmodule

// File: rtl/tds_checker.sv
module tds_checker #(
    parameter int unsigned DATA_W = 4,
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwdn,
    input logic             energy,
    input logic             sd,
    input logic             digit0,
    input logic             ack_rise,
    input logic             ack_fall,
    input logic             window,
    input logic             data_bit,
    input logic             armed,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    AST_PWDN_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn |-> !sd); // R8
    AST_IDLE_SHOWS_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwdn && !window) |-> (sd == energy)); // R1
    AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window) |-> $past(armed)); // R2
    AST_FIRST_BIT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window) |-> (data_bit == $past(digit0))); // R3
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (window && $past(window) && !$past(ack_rise)) |-> $stable(data_bit)); // R4
    AST_WINDOW_ENDS_ON_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window) |-> ($past(count) == LAST && $past(ack_fall))); // R5
endmodule

bind tone_digit_shifter tds_checker #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwdn     (pwdn),
    .energy   (energy),
    .sd       (sd),
    .digit0   (digit[0]),
    .ack_rise (ack_rise),
    .ack_fall (ack_fall),
    .window   (window),
    .data_bit (data_bit),
    .armed    (armed),
    .count    (count)
);

// File: tb/tone_digit_shifter_tb_top.sv
module tone_digit_shifter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       steer = 1'b0;
    logic [3:0] digit = 4'b0000;
    logic       ack = 1'b0;
    logic       energy = 1'b0;
    logic       pwdn = 1'b0;
    logic       sd;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_digit_shifter dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .steer  (steer),
        .digit  (digit),
        .ack    (ack),
        .energy (energy),
        .pwdn   (pwdn),
        .sd     (sd)
    );

    // monitor: compares at falling edges against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (sd !== e) begin
                    failures++;
                    $display("FAIL %s sd actual=%0b expected=%0b at %0t", t, sd, e, $time);
                end
            end
        end
    end

    task automatic drive_slot();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input logic e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic settle_check(input logic e, input string t);
        @(posedge clk);
        #1;
        push(e, t);
    endtask

    task automatic set_steer(input logic v);
        drive_slot();
        steer = v;
        @(posedge clk);
    endtask

    task automatic set_energy(input logic v);
        drive_slot();
        energy = v;
    endtask

    // one ack pulse: prev = sd two edges after rise, hi = after third edge,
    // lo = sd four edges after fall
    task automatic pulse(input logic prev, input logic hi, input logic lo, input string t);
        drive_slot();
        ack = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        push(prev, t);
        @(posedge clk);
        #1;
        push(hi, t);
        @(posedge clk);
        drive_slot();
        ack = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        push(lo, t);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        drive_slot();
        rst_n = 1'b1;
        settle_check(1'b0, "R1");
        set_energy(1'b1);
        settle_check(1'b1, "R1");

        // not armed: pulses ignored, key 0 code has bit0 = 0
        digit = 4'b1010;
        pulse(1'b1, 1'b1, 1'b1, "R2");

        // readout of key 0 (1010)
        set_steer(1'b1);
        pulse(1'b1, 1'b0, 1'b0, "R9");
        digit = 4'b0101;                       // R3: change after capture
        set_energy(1'b0);
        pulse(1'b0, 1'b1, 1'b1, "R5");         // window persists with energy low
        pulse(1'b1, 1'b0, 1'b0, "R4");
        pulse(1'b0, 1'b1, 1'b0, "R5");         // after fourth fall: energy

        // excess pulse without new steering edge
        set_energy(1'b1);
        digit = 4'b1100;
        pulse(1'b1, 1'b1, 1'b1, "R7");

        // re-arm, read # (1100)
        set_steer(1'b0);
        set_steer(1'b1);
        pulse(1'b1, 1'b0, 1'b0, "R3");
        pulse(1'b0, 1'b0, 1'b0, "R4");
        pulse(1'b0, 1'b1, 1'b1, "R4");
        set_energy(1'b0);
        pulse(1'b1, 1'b1, 1'b0, "R4");

        // partial readout of 9 (1001), steering edge in the middle
        set_energy(1'b1);
        set_steer(1'b0);
        digit = 4'b1001;
        set_steer(1'b1);
        pulse(1'b1, 1'b1, 1'b1, "R6");
        pulse(1'b1, 1'b0, 1'b0, "R6");
        set_steer(1'b0);
        digit = 4'b0000;
        set_steer(1'b1);                       // discarded
        pulse(1'b0, 1'b0, 1'b0, "R6");
        set_energy(1'b0);
        pulse(1'b0, 1'b1, 1'b0, "R6");
        set_energy(1'b1);
        pulse(1'b1, 1'b1, 1'b1, "R6");         // no capture of D

        // powerdown with key C (1111)
        set_steer(1'b0);
        digit = 4'b1111;
        set_steer(1'b1);
        drive_slot();
        pwdn = 1'b1;
        settle_check(1'b0, "R8");
        drive_slot();
        pwdn = 1'b0;
        settle_check(1'b1, "R8");
        set_energy(1'b0);
        pulse(1'b0, 1'b1, 1'b1, "R8");
        drive_slot();
        pwdn = 1'b1;
        settle_check(1'b0, "R8");
        drive_slot();
        pwdn = 1'b0;
        settle_check(1'b1, "R8");
        pulse(1'b1, 1'b1, 1'b1, "R8");
        pulse(1'b1, 1'b1, 1'b1, "R8");
        pulse(1'b1, 1'b1, 1'b0, "R8");

        // key D (0000) read with energy high
        set_energy(1'b1);
        set_steer(1'b0);
        digit = 4'b0000;
        set_steer(1'b1);
        pulse(1'b1, 1'b0, 1'b0, "R3");
        pulse(1'b0, 1'b0, 1'b0, "R4");
        pulse(1'b0, 1'b0, 1'b0, "R4");
        pulse(1'b0, 1'b0, 1'b1, "R5");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule